// File: doc/BRIEF.md
# Sixteen-Bit Ten-Function ALU

This is a purely combinational arithmetic and logic unit. It takes two 16-bit two's-complement operands and a 4-bit operation code, and it returns one 16-bit result in the same evaluation. It has no clock and no internal state. It is meant to sit inside a processor datapath, where the operation code comes directly from instruction decode.

Addition and subtraction share one ripple-carry adder. For subtraction, the adder's second input is inverted and its carry-in is forced high. A shift-and-add array of sixteen conditional partial products forms the product. A logarithmic barrel shifter handles all three shift kinds. The shifter always moves the first operand, and the shift distance comes from the low four bits of the second operand. A sixteen-entry selector indexed by the operation code picks the result. Entries with no operation assigned to them return zero.

Top module: `alu16`

## Requirements
- R1: Code 4'b0100 gives result = opnd_a + opnd_b, modulo 2^16.
- R2: Code 4'b0101 gives result = opnd_a - opnd_b, modulo 2^16.
- R3: Code 4'b0110 gives the low 16 bits of the signed product opnd_a * opnd_b.
- R4: Code 4'b1000 gives the bitwise OR of the two operands.
- R5: Code 4'b1001 gives the bitwise inverse of opnd_a, and opnd_b has no effect.
- R6: Code 4'b1010 gives the bitwise AND of the two operands.
- R7: Code 4'b1011 gives the bitwise XOR of the two operands.
- R8: Code 4'b1100 shifts opnd_a left by opnd_b[3:0] and fills with zeros. opnd_b[15:4] is ignored.
- R9: Code 4'b1101 shifts opnd_a right by opnd_b[3:0] and fills with zeros.
- R10: Code 4'b1110 shifts opnd_a right by opnd_b[3:0] and fills with copies of opnd_a[15].
- R11: Codes 4'b0000 to 4'b0011, 4'b0111 and 4'b1111 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand; also the value that is shifted or inverted |
| opnd_b | input | 16 | Second operand; its low 4 bits are the shift distance |
| ctrl | input | 4 | Operation code |
| result | output | 16 | Selected result |

## Verification
The assertions assume that the operands and the operation code are fully known, two-valued and stable whenever they are evaluated. The block has no handshake, so its output is meaningful only once the inputs have settled. The bench meets this by changing the inputs only at one clock edge and comparing the result half a period later. Stimulus mixes every operation code with seeded random operands and with directed signed corner values: zero, one, all ones, the most negative value and the most positive value. These corner operands are combined with shift distances of 0, 15 and values whose upper bits are set.

// File: rtl/alu16.sv
module alu16 #(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   ctrl,
  output logic [W-1:0] result
);
  localparam int SW = $clog2(W);

  logic         do_sub;
  logic [W-1:0] add_b, sum;
  logic [W:0]   cy;

  assign do_sub = (ctrl == 4'b0101);
  assign add_b  = opnd_b ^ {W{do_sub}};
  assign cy[0]  = do_sub;

  for (genvar i = 0; i < W; i++) begin : g_add
    assign sum[i]  = opnd_a[i] ^ add_b[i] ^ cy[i];
    assign cy[i+1] = (opnd_a[i] & add_b[i]) | (cy[i] & (opnd_a[i] ^ add_b[i]));
  end

  logic [W-1:0] pacc [W+1];
  assign pacc[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_mul
    assign pacc[i+1] = pacc[i] + (opnd_b[i] ? (opnd_a << i) : '0);
  end

  logic [W-1:0] stg [SW+1];
  logic         go_left, fill;
  assign go_left = (ctrl[1:0] == 2'b00);
  assign fill    = ctrl[1] & opnd_a[W-1];
  assign stg[0]  = opnd_a;

  for (genvar k = 0; k < SW; k++) begin : g_shf
    localparam int D = 1 << k;
    assign stg[k+1] = !opnd_b[k] ? stg[k] :
                      go_left    ? {stg[k][W-1-D:0], {D{1'b0}}} :
                                   {{D{fill}}, stg[k][W-1:D]};
  end

  logic [W-1:0] choice [16];
  always_comb begin
    for (int c = 0; c < 16; c++) choice[c] = '0;
    choice[4'b0100] = sum;
    choice[4'b0101] = sum;
    choice[4'b0110] = pacc[W];
    choice[4'b1000] = opnd_a | opnd_b;
    choice[4'b1001] = ~opnd_a;
    choice[4'b1010] = opnd_a & opnd_b;
    choice[4'b1011] = opnd_a ^ opnd_b;
    choice[4'b1100] = stg[SW];
    choice[4'b1101] = stg[SW];
    choice[4'b1110] = stg[SW];
  end

  assign result = choice[ctrl];
endmodule

module alu16_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   ctrl,
  input logic [W-1:0] result
);
  localparam int SW = $clog2(W);
  logic [W-1:0] amt;
  assign amt = W'(opnd_b[SW-1:0]);

  always_comb begin
    if (ctrl == 4'b0100) AST_ADD_SUM: assert (result == W'(opnd_a + opnd_b)); // R1
    if (ctrl == 4'b0101) AST_SUB_DIFF: assert (result == W'(opnd_a - opnd_b)); // R2
    if (ctrl == 4'b0110) AST_MUL_LOW: assert (result == W'($signed(opnd_a) * $signed(opnd_b))); // R3
    if (ctrl == 4'b1001) AST_NOT_A: assert ((result ^ opnd_a) == {W{1'b1}}); // R5
    if (ctrl == 4'b1100) AST_SLL_LEFT: assert (result == (opnd_a << amt)); // R8
    if (ctrl == 4'b1110) AST_SRA_SIGN: assert (result == W'($signed(opnd_a) >>> amt)); // R10
    if (ctrl[3:2] == 2'b00 || ctrl == 4'b0111 || ctrl == 4'b1111)
      AST_UNUSED_ZERO: assert (result == '0); // R11
  end
endmodule

bind alu16 alu16_chk #(.W(W)) i_alu16_chk (.*);

// File: tb/test_alu16.sv
module test_alu16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opnd_a = '0, opnd_b = '0, result;
  logic [3:0]  ctrl = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  alu16 i_alu16 (.opnd_a(opnd_a), .opnd_b(opnd_b), .ctrl(ctrl), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic [3:0] c);
    int s = int'(b[3:0]);
    case (c)
      4'b0100: return a + b;
      4'b0101: return a - b;
      4'b0110: return 16'($signed(a) * $signed(b));
      4'b1000: return a | b;
      4'b1001: return ~a;
      4'b1010: return a & b;
      4'b1011: return a ^ b;
      4'b1100: return a << s;
      4'b1101: return a >> s;
      4'b1110: return 16'($signed(a) >>> s);
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c)
      4'b0100: return "R1";
      4'b0101: return "R2";
      4'b0110: return "R3";
      4'b1000: return "R4";
      4'b1001: return "R5";
      4'b1010: return "R6";
      4'b1011: return "R7";
      4'b1100: return "R8";
      4'b1101: return "R9";
      4'b1110: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(logic [15:0] a, logic [15:0] b, logic [3:0] c);
    logic [15:0] exp;
    @(posedge clk);
    opnd_a = a; opnd_b = b; ctrl = c;
    exp = model(a, b, c);
    @(negedge clk);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s ctrl=%b a=%h b=%h actual=%h expected=%h", tag(c), c, a, b, result, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] corner [6];
    void'($urandom(32'd5177));
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
    corner[3] = 16'h8000; corner[4] = 16'h7FFF; corner[5] = 16'hFFF0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs select an unused code (R11)
    run(16'h0, 16'h0, 4'b0000);
    // R5: opnd_b must not affect NOT
    run(16'h1234, 16'hFFFF, 4'b1001);
    run(16'h1234, 16'h0000, 4'b1001);
    // R8, R9, R10: upper shift bits ignored; extreme distances
    run(16'h8001, 16'hFFF0, 4'b1100);
    run(16'h8001, 16'h000F, 4'b1101);
    run(16'h8001, 16'h000F, 4'b1110);
    run(16'h4000, 16'h00F1, 4'b1110);
    // R3: most negative squared, R1/R2 wrap
    run(16'h8000, 16'h8000, 4'b0110);
    run(16'h7FFF, 16'h0001, 4'b0100);
    run(16'h8000, 16'h0001, 4'b0101);
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run(corner[i], corner[j], 4'(c));
    for (int n = 0; n < 3000; n++)
      run(16'($urandom), 16'($urandom), 4'($urandom));
    finish_run();
  end
endmodule